// File: doc/BRIEF.md
# Hierarchical Interrupt Aggregator

This block gathers single-cycle event pulses from many on-chip detectors (regulator monitors, temperature sensors, pin checkers, link checkers) and turns each into a sticky pending flag. Software clears a flag by writing 1 to it. The sources are arranged in nine categories of sixteen sources each. Every category has its own flag register and its own mask register. A read-only summary register holds one bit per category, so a host reads the summary first and then only the category that is pending.

All pending flags drive one registered, active-low interrupt line. A mask bit blocks recording: a masked event leaves no trace in the flags. A flag set before its mask was raised stays set and keeps driving the line. Sources with a live condition input refuse a clear while that condition is still present. The GPIO category records rising and falling edges and has a separate mask for each polarity.

Top module: `irq_aggregator`

## Requirements
- R1: After reset all flags and masks read 0, the summary reads 0, and the interrupt line is high.
- R2: An unmasked event sampled at a clock edge sets its flag at that edge. The interrupt line goes low at the same edge.
- R3: Writing a flag register clears exactly the bits written as 1. Bits written as 0 keep their value. The line returns high once no flag is pending.
- R4: An event whose mask bit is 1 does not set its flag and does not pull the interrupt line low.
- R5: A flag that was set before its mask bit was raised stays set, keeps the line low and is still cleared by a write of 1.
- R6: A write-1 clear is refused for every bit whose live input is 1. Once the live input returns to 0, the same write clears the flag.
- R7: When an event and a write-1 clear hit the same bit in the same cycle, the flag stays set.
- R8: Flags are sticky and independent. Clearing one pending flag leaves the others set, and the line stays low until the last one is cleared.
- R9: The summary at address 0x3F has bit c equal to the OR of category c's flags. The categories in bit order are: 0 buck, 1 LDO, 2 supply monitor, 3 severe, 4 moderate, 5 miscellaneous, 6 start-up source, 7 GPIO, 8 state-machine. Writes to the summary are ignored.
- R10: For GPIO (category 7), the rise mask sits at address 0x17 and the fall mask at 0x30. The rising edge of a source comes in on its event bit and the falling edge on its own fall input. An edge whose polarity is masked does not set the flag, and the opposite polarity still does.
- R11: Category c's flags are at address 0x00+c, its masks at 0x10+c and its live inputs at 0x20+c. Reads of any other address return 0, and writes to any other address change nothing.
- R12: Read data is registered. The address present at a clock edge selects the value that appears on the read port after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| evt_i | input | 144 | Event pulses, 16 per category, category c at bits 16c+15..16c; for GPIO these are rising edges |
| live_i | input | 144 | Live condition per source; a 1 blocks clearing of that flag |
| gpio_fall_i | input | 16 | GPIO falling-edge events |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| irq_n_o | output | 1 | Active-low interrupt, low while any flag is pending |

## Verification
A flag bit stuck wrong shows on the interrupt line at the very next edge. It also shows one cycle later on a read of the flag register or of the summary. The two views come from separate logic and must agree. A mask that gates only the line rather than recording is exposed by unmasking after a masked event: a stale flag then appears at once. A clear that ignores the live input, or that wins a same-cycle race with an event, shows up on the readback that immediately follows the write.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam int NUM_CAT = 9;
  localparam int SRC_W   = 16;
  localparam int ADDR_W  = 6;

  // category order is the summary bit order
  typedef enum logic [3:0] {
    CAT_BUCK     = 4'd0,
    CAT_LDO      = 4'd1,
    CAT_VMON     = 4'd2,
    CAT_SEVERE   = 4'd3,
    CAT_MODERATE = 4'd4,
    CAT_MISC     = 4'd5,
    CAT_STARTUP  = 4'd6,
    CAT_GPIO     = 4'd7,
    CAT_FSM      = 4'd8
  } cat_e;

  // upper two address bits select the register region
  localparam logic [1:0] REGION_FLAG = 2'd0;
  localparam logic [1:0] REGION_MASK = 2'd1;
  localparam logic [1:0] REGION_LIVE = 2'd2;
  localparam logic [1:0] REGION_AUX  = 2'd3;

endpackage

// File: rtl/irq_cat_bank.sv
module irq_cat_bank #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic [W-1:0] evt_a_i,
  input  logic [W-1:0] evt_b_i,
  input  logic [W-1:0] mask_a_i,
  input  logic [W-1:0] mask_b_i,
  input  logic [W-1:0] live_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] clr_data_i,
  output logic [W-1:0] flag_q_o,
  output logic [W-1:0] flag_nxt_o
);

  logic [W-1:0] set_v;
  logic [W-1:0] clr_v;
  logic [W-1:0] flag_q;

  // masking removes the event before it can be recorded
  assign set_v = (evt_a_i & ~mask_a_i) | (evt_b_i & ~mask_b_i);
  // a live condition vetoes the clear of its bit
  assign clr_v = clr_en_i ? (clr_data_i & ~live_i) : '0;
  // set dominates clear
  assign flag_nxt_o = set_v | (flag_q & ~clr_v);

  always_ff @(posedge clk_i) begin
    if (rst_i) flag_q <= '0;
    else       flag_q <= flag_nxt_o;
  end

  assign flag_q_o = flag_q;

  // R4
  mask_block_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ((flag_q & ~$past(flag_q) & ~$past(set_v)) == '0))
    else $error("newly set flag without an unmasked event");

  // R6
  clr_refuse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (clr_en_i && ((clr_data_i & live_i & flag_q) != '0)) |=>
    ((flag_q & $past(clr_data_i & live_i & flag_q)) == $past(clr_data_i & live_i & flag_q)))
    else $error("flag cleared while its live input was set");

  // R7
  evt_win_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (set_v != '0) |=> ((flag_q & $past(set_v)) == $past(set_v)))
    else $error("unmasked event did not leave its flag set");

endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port #(
  parameter int NCAT     = 9,
  parameter int W        = 16,
  parameter int AW       = 6,
  parameter int GPIO_CAT = 7
) (
  input  logic                     clk_i,
  input  logic                     rst_i,
  input  logic                     wr_en_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [W-1:0]             wdata_i,
  input  logic [NCAT-1:0][W-1:0]   flags_i,
  input  logic [NCAT-1:0][W-1:0]   live_i,
  input  logic [NCAT-1:0]          summary_i,
  output logic [NCAT-1:0][W-1:0]   mask_o,
  output logic [W-1:0]             fall_mask_o,
  output logic [NCAT-1:0]          clr_en_o,
  output logic [W-1:0]             rdata_o
);
  import irq_agg_pkg::*;

  localparam int IDX_W = AW - 2;
  localparam logic [IDX_W:0]   NCAT_V   = (IDX_W+1)'(NCAT);
  localparam logic [IDX_W-1:0] FALL_IDX = '0;
  localparam logic [IDX_W-1:0] SUM_IDX  = '1;

  logic [1:0]       region;
  logic [IDX_W-1:0] idx;
  logic             idx_ok;
  logic [W-1:0]     rd_d;
  logic [W-1:0]     rdata_q;
  logic [W-1:0]     fall_q;

  assign region = addr_i[AW-1:AW-2];
  assign idx    = addr_i[IDX_W-1:0];
  assign idx_ok = ({1'b0, idx} < NCAT_V);

  for (genvar c = 0; c < NCAT; c++) begin : g_cat
    logic mask_hit;
    assign mask_hit    = wr_en_i && (region == REGION_MASK) && (idx == IDX_W'(c));
    assign clr_en_o[c] = wr_en_i && (region == REGION_FLAG) && (idx == IDX_W'(c));

    always_ff @(posedge clk_i) begin
      if (rst_i)         mask_o[c] <= '0;
      else if (mask_hit) mask_o[c] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)
      fall_q <= '0;
    else if (wr_en_i && (region == REGION_AUX) && (idx == FALL_IDX))
      fall_q <= wdata_i;
  end
  assign fall_mask_o = fall_q;

  always_comb begin
    rd_d = '0;
    case (region)
      REGION_FLAG: if (idx_ok) rd_d = flags_i[idx];
      REGION_MASK: if (idx_ok) rd_d = mask_o[idx];
      REGION_LIVE: if (idx_ok) rd_d = live_i[idx];
      default: begin
        if (idx == FALL_IDX)     rd_d = fall_q;
        else if (idx == SUM_IDX) rd_d[NCAT-1:0] = summary_i;
      end
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) rdata_q <= '0;
    else       rdata_q <= rd_d;
  end
  assign rdata_o = rdata_q;

  // R11
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !(wr_en_i && (region == REGION_MASK)) |=> $stable(mask_o))
    else $error("mask changed without a mask write");

endmodule

// File: rtl/irq_pin_out.sv
module irq_pin_out #(
  parameter int NCAT = 9,
  parameter int W    = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_i,
  input  logic [NCAT-1:0][W-1:0] flag_q_i,
  input  logic [NCAT-1:0][W-1:0] flag_nxt_i,
  output logic [NCAT-1:0]        summary_o,
  output logic                   irq_n_o
);

  logic irq_n_q;

  for (genvar c = 0; c < NCAT; c++) begin : g_sum
    assign summary_o[c] = |flag_q_i[c];
  end

  // registered from the next-state flags so the line moves with the flags
  always_ff @(posedge clk_i) begin
    if (rst_i) irq_n_q <= 1'b1;
    else       irq_n_q <= ~(|flag_nxt_i);
  end
  assign irq_n_o = irq_n_q;

  // R2
  pin_sync_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_n_q == ~(|flag_q_i))
    else $error("interrupt line disagrees with pending flags");

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int NCAT     = irq_agg_pkg::NUM_CAT,
  parameter int W        = irq_agg_pkg::SRC_W,
  parameter int AW       = irq_agg_pkg::ADDR_W,
  parameter int GPIO_CAT = int'(irq_agg_pkg::CAT_GPIO)
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [NCAT*W-1:0] evt_i,
  input  logic [NCAT*W-1:0] live_i,
  input  logic [W-1:0]      gpio_fall_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  output logic              irq_n_o
);

  logic [NCAT-1:0][W-1:0] evt_2d;
  logic [NCAT-1:0][W-1:0] live_2d;
  logic [NCAT-1:0][W-1:0] mask_2d;
  logic [NCAT-1:0][W-1:0] flag_q;
  logic [NCAT-1:0][W-1:0] flag_nxt;
  logic [NCAT-1:0]        clr_en;
  logic [NCAT-1:0]        summary;
  logic [W-1:0]           fall_mask;

  assign evt_2d  = evt_i;
  assign live_2d = live_i;

  for (genvar c = 0; c < NCAT; c++) begin : g_bank
    if (c == GPIO_CAT) begin : g_edge
      irq_cat_bank #(.W(W)) u_bank (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .evt_a_i    (evt_2d[c]),
        .evt_b_i    (gpio_fall_i),
        .mask_a_i   (mask_2d[c]),
        .mask_b_i   (fall_mask),
        .live_i     (live_2d[c]),
        .clr_en_i   (clr_en[c]),
        .clr_data_i (wdata_i),
        .flag_q_o   (flag_q[c]),
        .flag_nxt_o (flag_nxt[c])
      );
    end else begin : g_level
      irq_cat_bank #(.W(W)) u_bank (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .evt_a_i    (evt_2d[c]),
        .evt_b_i    ('0),
        .mask_a_i   (mask_2d[c]),
        .mask_b_i   ('1),
        .live_i     (live_2d[c]),
        .clr_en_i   (clr_en[c]),
        .clr_data_i (wdata_i),
        .flag_q_o   (flag_q[c]),
        .flag_nxt_o (flag_nxt[c])
      );
    end
  end

  irq_reg_port #(.NCAT(NCAT), .W(W), .AW(AW), .GPIO_CAT(GPIO_CAT)) u_regs (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .wr_en_i     (wr_en_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .flags_i     (flag_q),
    .live_i      (live_2d),
    .summary_i   (summary),
    .mask_o      (mask_2d),
    .fall_mask_o (fall_mask),
    .clr_en_o    (clr_en),
    .rdata_o     (rdata_o)
  );

  irq_pin_out #(.NCAT(NCAT), .W(W)) u_pin (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .flag_q_i   (flag_q),
    .flag_nxt_i (flag_nxt),
    .summary_o  (summary),
    .irq_n_o    (irq_n_o)
  );

endmodule

// File: tb/sim_irq_aggregator.sv
`timescale 1ns/100ps
module sim_irq_aggregator;
  localparam int NCAT = 9;
  localparam int W    = 16;
  localparam int AW   = 6;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NCAT*W-1:0] evt = '0;
  logic [NCAT*W-1:0] live = '0;
  logic [W-1:0]      gfall = '0;
  logic              wr_en = 1'b0;
  logic [AW-1:0]     addr = '0;
  logic [W-1:0]      wdata = '0;
  logic [W-1:0]      rdata;
  logic              irq_n;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  irq_aggregator u0 (
    .clk_i(clk), .rst_i(rst), .evt_i(evt), .live_i(live), .gpio_fall_i(gfall),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_n_o(irq_n)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [W-1:0] d);
    @(negedge clk); addr = a;
    @(posedge clk); #1 d = rdata;
  endtask

  task automatic pulse(input int cat, input int b);
    @(negedge clk); evt[cat*W+b] = 1'b1;
    @(negedge clk); evt[cat*W+b] = 1'b0;
  endtask

  task automatic t_reset;
    logic [W-1:0] v;
    chk("R1 line", {15'd0, irq_n}, 16'd1);
    rd(6'h00, v); chk("R1 flag", v, 16'h0);
    rd(6'h10, v); chk("R1 mask", v, 16'h0);
    rd(6'h3F, v); chk("R1 summary", v, 16'h0);
  endtask

  task automatic t_set_clear;
    logic [W-1:0] v;
    @(negedge clk); evt[0*W+3] = 1'b1;
    @(posedge clk); #1 chk("R2 line same edge", {15'd0, irq_n}, 16'd0);
    @(negedge clk); evt[0*W+3] = 1'b0;
    rd(6'h00, v); chk("R2 flag", v, 16'h0008);
    wr(6'h00, 16'h0000);
    rd(6'h00, v); chk("R3 write0 keeps", v, 16'h0008);
    wr(6'h00, 16'h0008);
    rd(6'h00, v); chk("R3 write1 clears", v, 16'h0000);
    chk("R3 line high", {15'd0, irq_n}, 16'd1);
  endtask

  task automatic t_mask;
    logic [W-1:0] v;
    wr(6'h11, 16'h0001);
    pulse(1, 0);
    chk("R4 line stays high", {15'd0, irq_n}, 16'd1);
    rd(6'h01, v); chk("R4 not recorded", v, 16'h0000);
    pulse(1, 1);
    rd(6'h01, v); chk("R4 unmasked bit", v, 16'h0002);
    wr(6'h01, 16'h0002);
    wr(6'h11, 16'h0000);
  endtask

  task automatic t_mask_after;
    logic [W-1:0] v;
    pulse(2, 5);
    wr(6'h12, 16'hFFFF);
    pulse(2, 5);
    rd(6'h02, v); chk("R5 flag kept", v, 16'h0020);
    chk("R5 line low", {15'd0, irq_n}, 16'd0);
    wr(6'h02, 16'h0020);
    rd(6'h02, v); chk("R5 cleared", v, 16'h0000);
    chk("R5 line high", {15'd0, irq_n}, 16'd1);
    wr(6'h12, 16'h0000);
  endtask

  task automatic t_live;
    logic [W-1:0] v;
    @(negedge clk); live[4*W+2] = 1'b1;
    pulse(4, 2);
    wr(6'h04, 16'h0004);
    rd(6'h04, v); chk("R6 clear refused", v, 16'h0004);
    rd(6'h24, v); chk("R11 live read", v, 16'h0004);
    @(negedge clk); live[4*W+2] = 1'b0;
    wr(6'h04, 16'h0004);
    rd(6'h04, v); chk("R6 clear after live drop", v, 16'h0000);
  endtask

  task automatic t_race;
    logic [W-1:0] v;
    pulse(3, 0);
    @(negedge clk); evt[3*W+0] = 1'b1; wr_en = 1'b1; addr = 6'h03; wdata = 16'h0001;
    @(negedge clk); evt[3*W+0] = 1'b0; wr_en = 1'b0;
    rd(6'h03, v); chk("R7 event beats clear", v, 16'h0001);
    wr(6'h03, 16'h0001);
  endtask

  task automatic t_sticky;
    logic [W-1:0] v;
    pulse(5, 0);
    pulse(8, 7);
    rd(6'h3F, v); chk("R9 summary two cats", v, 16'h0120);
    wr(6'h05, 16'h0001);
    chk("R8 line still low", {15'd0, irq_n}, 16'd0);
    rd(6'h08, v); chk("R8 other flag kept", v, 16'h0080);
    rd(6'h3F, v); chk("R9 summary one cat", v, 16'h0100);
    wr(6'h08, 16'h0080);
    chk("R8 line high at end", {15'd0, irq_n}, 16'd1);
  endtask

  task automatic t_gpio;
    logic [W-1:0] v;
    wr(6'h17, 16'h0001);
    wr(6'h30, 16'h0002);
    pulse(7, 0);
    rd(6'h07, v); chk("R10 masked rise", v, 16'h0000);
    @(negedge clk); gfall[0] = 1'b1;
    @(negedge clk); gfall[0] = 1'b0;
    rd(6'h07, v); chk("R10 fall still records", v, 16'h0001);
    wr(6'h07, 16'h0001);
    @(negedge clk); gfall[1] = 1'b1;
    @(negedge clk); gfall[1] = 1'b0;
    rd(6'h07, v); chk("R10 masked fall", v, 16'h0000);
    pulse(7, 1);
    rd(6'h07, v); chk("R10 rise still records", v, 16'h0002);
    rd(6'h30, v); chk("R10 fall mask read", v, 16'h0002);
    wr(6'h07, 16'h0002);
    wr(6'h17, 16'h0000);
    wr(6'h30, 16'h0000);
  endtask

  task automatic t_addr;
    logic [W-1:0] v;
    pulse(0, 0);
    wr(6'h3F, 16'hFFFF);
    wr(6'h0A, 16'hFFFF);
    wr(6'h1A, 16'hFFFF);
    wr(6'h2A, 16'hFFFF);
    rd(6'h00, v); chk("R11 flag untouched", v, 16'h0001);
    rd(6'h1A, v); chk("R11 undefined reads 0", v, 16'h0000);
    rd(6'h10, v); chk("R11 mask untouched", v, 16'h0000);
    rd(6'h3F, v); chk("R9 summary read-only", v, 16'h0001);
    // R12: read port holds the value picked at the previous edge
    @(negedge clk); addr = 6'h00;
    #0.5 chk("R12 before edge", rdata, 16'h0001);
    @(negedge clk); addr = 6'h1A;
    #0.5 chk("R12 old value held", rdata, 16'h0001);
    @(posedge clk); #1 chk("R12 after edge", rdata, 16'h0000);
    wr(6'h00, 16'h0001);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_set_clear();
    t_mask();
    t_mask_after();
    t_live();
    t_race();
    t_sticky();
    t_gpio();
    t_addr();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule